// File: doc/BRIEF.md
# Speculative Store Buffer with Load Forwarding

This block holds stores that have left the pipeline's issue stage but have not yet been written into the level-one data cache. A store takes a slot when it is allocated, which may happen before its data exists or before it is known to be on the correct path. Its data is filled in later by tag. The store is committed once it is no longer speculative, or it is aborted and discarded. The slots form a circular queue in program order. The oldest slot is written to the cache through a valid/ready drain port once it is committed and its data is present.

Every load address is presented to this block in the same cycle as it is presented to the cache. The cache's read data comes in on `ld_cache_data`. When valid slots hold the load's address, the youngest of them in program order decides the result. If that slot has its data, the data overrides the cache value. If it has none, the block raises a pending flag so the load can be replayed. Forwarding ignores the speculative bit.

Two ports follow valid/ready back-pressure rules. An allocation is taken on a cycle where `alloc_valid` and `alloc_ready` are both high. A drain write is taken on a cycle where `drain_valid` and `drain_ready` are both high. While `drain_ready` is low, `drain_valid`, `drain_addr` and `drain_data` stay unchanged. Fill, commit, abort and lookup are plain single-cycle controls.

Top module: `ssb_store_buffer`

## Requirements
- R1: An accepted allocation takes the slot whose index is shown on `alloc_tag`. Indices are handed out in increasing order modulo DEPTH, starting at 0 after reset. The new slot is valid and speculative, and holds no data.
- R2: `alloc_ready` is low exactly when all DEPTH slots are occupied. A slot is occupied from its allocation until the head of the queue releases it.
- R3: A fill writes `fill_data` into slot `fill_tag` only if that slot is valid and holds no data yet. In any other case the fill is ignored.
- R4: When `ld_valid` is high and the youngest valid slot whose address equals `ld_addr` holds data, `ld_hit` is 1 and `ld_data` is that slot's data, overriding `ld_cache_data`. This happens in the same cycle. With no matching slot, `ld_hit` and `ld_pending` are 0 and `ld_data` equals `ld_cache_data`.
- R5: When the youngest matching slot holds no data, `ld_pending` is 1, `ld_hit` is 0 and `ld_data` equals `ld_cache_data`.
- R6: The youngest matching slot is the last match in program order, walking from the head towards the tail. Older slots with the same address are overridden.
- R7: A commit clears the speculative bit of a valid speculative slot. An abort invalidates a valid speculative slot so it no longer matches loads. Both are ignored on slots that are not speculative. When both name the same slot in one cycle, the abort wins.
- R8: `drain_valid` is high when the head slot is valid, committed and holds data, with that slot's address and data on the drain port. On a handshake the slot is released. While the port is stalled, its outputs hold.
- R9: An invalidated slot at the head is released with no drain write. At most one slot is released per cycle.
- R10: After reset the buffer is empty: `alloc_ready` is 1, `alloc_tag` is 0, and `drain_valid`, `ld_hit` and `ld_pending` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_ready | output | 1 | A free slot exists |
| alloc_addr | input | ADDR_W | Store address of the allocation |
| alloc_tag | output | log2(DEPTH) | Slot index the next allocation takes |
| fill_valid | input | 1 | Data fill strobe |
| fill_tag | input | log2(DEPTH) | Slot to fill |
| fill_data | input | DATA_W | Store data |
| commit_valid | input | 1 | Commit strobe |
| commit_tag | input | log2(DEPTH) | Slot to commit |
| abort_valid | input | 1 | Abort strobe |
| abort_tag | input | log2(DEPTH) | Slot to discard |
| ld_valid | input | 1 | Load lookup request |
| ld_addr | input | ADDR_W | Load address |
| ld_cache_data | input | DATA_W | Data read from the cache for the same load |
| ld_hit | output | 1 | Buffer supplies the load data |
| ld_pending | output | 1 | Youngest match has no data yet; replay the load |
| ld_data | output | DATA_W | Merged load data |
| drain_valid | output | 1 | Drain write offered to the cache |
| drain_ready | input | 1 | Cache accepts the drain write |
| drain_addr | output | ADDR_W | Drain write address |
| drain_data | output | DATA_W | Drain write data |

## Verification
The lookup outputs are combinational and are due in the same cycle the load is presented. `alloc_ready`, `alloc_tag` and the drain port reflect slot state, so they change one rising edge after the fill, commit, abort, allocation or drain handshake that caused the change. The bench changes inputs on the falling edge and compares every output 2 ns later against its model. It then advances the model with that cycle's inputs before the next rising edge. Each comparison is therefore made against the state the design holds between the two edges.

// File: rtl/ssb_pkg.sv
package ssb_pkg;
  typedef enum logic [1:0] {
    HD_IDLE  = 2'd0,
    HD_SKIP  = 2'd1,
    HD_DRAIN = 2'd2
  } head_act_e;
endpackage

// File: rtl/ssb_ring_ptr.sv
module ssb_ring_ptr #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  output logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] tail,
  output logic [CNT_W-1:0] count,
  output logic             full
);
  logic [IDX_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (push) tail_q <= (tail_q == IDX_W'(DEPTH-1)) ? '0 : tail_q + 1'b1;
      if (pop)  head_q <= (head_q == IDX_W'(DEPTH-1)) ? '0 : head_q + 1'b1;
      count_q <= count_q + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assign head  = head_q;
  assign tail  = tail_q;
  assign count = count_q;
  assign full  = (count_q == CNT_W'(DEPTH));

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(DEPTH)); // R2
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> count_q != '0); // R9
endmodule

// File: rtl/ssb_slot.sv
module ssb_slot #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_we,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic              fill_we,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              commit_we,
  input  logic              abort_we,
  input  logic              pop_we,
  output logic              valid_o,
  output logic              spec_o,
  output logic              rdy_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  logic              valid_q, spec_q, rdy_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              abort_ok, commit_ok, fill_ok;

  // Abort and commit act only on in-flight entries; fill only once.
  assign abort_ok  = abort_we  && valid_q && spec_q;
  assign commit_ok = commit_we && valid_q && spec_q;
  assign fill_ok   = fill_we   && valid_q && !rdy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      spec_q  <= 1'b0;
      rdy_q   <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else if (alloc_we) begin
      valid_q <= 1'b1;
      spec_q  <= 1'b1;
      rdy_q   <= 1'b0;
      addr_q  <= alloc_addr;
    end else if (pop_we) begin
      valid_q <= 1'b0;
    end else if (abort_ok) begin
      valid_q <= 1'b0;
    end else begin
      if (commit_ok) spec_q <= 1'b0;
      if (fill_ok) begin
        rdy_q  <= 1'b1;
        data_q <= fill_data;
      end
    end
  end

  assign valid_o = valid_q;
  assign spec_o  = spec_q;
  assign rdy_o   = rdy_q;
  assign addr_o  = addr_q;
  assign data_o  = data_q;

  AST_COMMITTED_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !spec_q && !pop_we && !alloc_we) |=> valid_q); // R7
  AST_DATA_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && rdy_q && !alloc_we) |=> $stable(data_q)); // R3
endmodule

// File: rtl/ssb_youngest.sv
module ssb_youngest #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int SUM_W = IDX_W + 1
) (
  input  logic [IDX_W-1:0]  head_i,
  input  logic [DEPTH-1:0]  valid_i,
  input  logic [DEPTH-1:0]  rdy_i,
  input  logic [ADDR_W-1:0] addr_i [DEPTH],
  input  logic [DATA_W-1:0] data_i [DEPTH],
  input  logic [ADDR_W-1:0] key_i,
  output logic              match_o,
  output logic              rdy_o,
  output logic [DATA_W-1:0] data_o
);
  // Walk from oldest to youngest; a later match replaces an earlier one.
  always_comb begin
    match_o = 1'b0;
    rdy_o   = 1'b0;
    data_o  = '0;
    for (int k = 0; k < DEPTH; k++) begin
      logic [SUM_W-1:0] sum;
      logic [IDX_W-1:0] idx;
      sum = {1'b0, head_i} + SUM_W'(k);
      idx = IDX_W'((sum >= SUM_W'(DEPTH)) ? sum - SUM_W'(DEPTH) : sum);
      if (valid_i[idx] && addr_i[idx] == key_i) begin
        match_o = 1'b1;
        rdy_o   = rdy_i[idx];
        data_o  = data_i[idx];
      end
    end
  end
endmodule

// File: rtl/ssb_store_buffer.sv
module ssb_store_buffer
  import ssb_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  output logic              alloc_ready,
  input  logic [ADDR_W-1:0] alloc_addr,
  output logic [IDX_W-1:0]  alloc_tag,
  input  logic              fill_valid,
  input  logic [IDX_W-1:0]  fill_tag,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              commit_valid,
  input  logic [IDX_W-1:0]  commit_tag,
  input  logic              abort_valid,
  input  logic [IDX_W-1:0]  abort_tag,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_cache_data,
  output logic              ld_hit,
  output logic              ld_pending,
  output logic [DATA_W-1:0] ld_data,
  output logic              drain_valid,
  input  logic              drain_ready,
  output logic [ADDR_W-1:0] drain_addr,
  output logic [DATA_W-1:0] drain_data
);
  logic [IDX_W-1:0]  head, tail;
  logic [CNT_W-1:0]  count;
  logic              full, push, pop;
  logic [DEPTH-1:0]  slot_valid, slot_spec, slot_rdy;
  logic [ADDR_W-1:0] slot_addr [DEPTH];
  logic [DATA_W-1:0] slot_data [DEPTH];
  head_act_e         head_act;
  logic              fwd_match, fwd_rdy;
  logic [DATA_W-1:0] fwd_data;

  assign alloc_ready = !full;
  assign alloc_tag   = tail;
  assign push        = alloc_valid && alloc_ready;

  ssb_ring_ptr #(.DEPTH(DEPTH)) u_ring (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .head(head), .tail(tail), .count(count), .full(full)
  );

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic sel_alloc, sel_fill, sel_commit, sel_abort, sel_pop;
    assign sel_alloc  = push && (tail == IDX_W'(g));
    assign sel_fill   = fill_valid && (fill_tag == IDX_W'(g));
    assign sel_commit = commit_valid && (commit_tag == IDX_W'(g));
    assign sel_abort  = abort_valid && (abort_tag == IDX_W'(g));
    assign sel_pop    = pop && (head == IDX_W'(g));

    ssb_slot #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .alloc_we(sel_alloc), .alloc_addr(alloc_addr),
      .fill_we(sel_fill), .fill_data(fill_data),
      .commit_we(sel_commit), .abort_we(sel_abort), .pop_we(sel_pop),
      .valid_o(slot_valid[g]), .spec_o(slot_spec[g]), .rdy_o(slot_rdy[g]),
      .addr_o(slot_addr[g]), .data_o(slot_data[g])
    );
  end

  // Head retirement: skip holes left by aborts, drain committed data.
  always_comb begin
    head_act = HD_IDLE;
    if (count != '0) begin
      if (!slot_valid[head])                        head_act = HD_SKIP;
      else if (!slot_spec[head] && slot_rdy[head])  head_act = HD_DRAIN;
    end
  end

  assign drain_valid = (head_act == HD_DRAIN);
  assign drain_addr  = slot_addr[head];
  assign drain_data  = slot_data[head];
  assign pop         = (head_act == HD_SKIP) || (drain_valid && drain_ready);

  ssb_youngest #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fwd (
    .head_i(head), .valid_i(slot_valid), .rdy_i(slot_rdy),
    .addr_i(slot_addr), .data_i(slot_data), .key_i(ld_addr),
    .match_o(fwd_match), .rdy_o(fwd_rdy), .data_o(fwd_data)
  );

  assign ld_hit     = ld_valid && fwd_match && fwd_rdy;
  assign ld_pending = ld_valid && fwd_match && !fwd_rdy;
  assign ld_data    = ld_hit ? fwd_data : ld_cache_data;

  AST_HIT_PEND_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_hit && ld_pending)); // R5
  AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_valid && !drain_ready) |=>
      (drain_valid && $stable(drain_addr) && $stable(drain_data))); // R8
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && count == CNT_W'(DEPTH-1)) |=> !alloc_ready); // R2
  AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (count != '0 && !slot_valid[head]) |-> !drain_valid); // R9
endmodule

// File: tb/sim_ssb_store_buffer.sv
module sim_ssb_store_buffer;
  localparam int DEPTH = 8;
  localparam int AW = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          alloc_valid = 0, alloc_ready;
  logic [AW-1:0] alloc_addr = '0;
  logic [2:0]    alloc_tag;
  logic          fill_valid = 0;
  logic [2:0]    fill_tag = '0;
  logic [DW-1:0] fill_data = '0;
  logic          commit_valid = 0;
  logic [2:0]    commit_tag = '0;
  logic          abort_valid = 0;
  logic [2:0]    abort_tag = '0;
  logic          ld_valid = 0;
  logic [AW-1:0] ld_addr = '0;
  logic [DW-1:0] ld_cache_data = '0;
  logic          ld_hit, ld_pending;
  logic [DW-1:0] ld_data;
  logic          drain_valid, drain_ready = 0;
  logic [AW-1:0] drain_addr;
  logic [DW-1:0] drain_data;

  ssb_store_buffer #(.DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW)) u0 (.*);

  int checks = 0;
  int fails = 0;

  // Reference model built from the requirements.
  bit          m_valid [DEPTH];
  bit          m_spec  [DEPTH];
  bit          m_rdy   [DEPTH];
  logic [AW-1:0] m_addr [DEPTH];
  logic [DW-1:0] m_data [DEPTH];
  int m_head = 0, m_tail = 0, m_count = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input bit av, input logic [AW-1:0] aa,
                      input bit fv, input int ft, input logic [DW-1:0] fd,
                      input bit cv, input int ct, input bit xv, input int xt,
                      input bit lv, input logic [AW-1:0] la, input logic [DW-1:0] cd,
                      input bit dr);
    bit e_dv, found, frdy, e_hit, e_pend, pop, acc;
    logic [DW-1:0] fdat;
    int h;
    bit n_valid [DEPTH];
    bit n_spec [DEPTH];
    bit n_rdy [DEPTH];
    logic [DW-1:0] n_data [DEPTH];
    @(negedge clk);
    alloc_valid = av; alloc_addr = aa;
    fill_valid = fv; fill_tag = 3'(ft); fill_data = fd;
    commit_valid = cv; commit_tag = 3'(ct);
    abort_valid = xv; abort_tag = 3'(xt);
    ld_valid = lv; ld_addr = la; ld_cache_data = cd;
    drain_ready = dr;
    #2;
    chk("R2 alloc_ready", 32'(alloc_ready), 32'(m_count < DEPTH));
    chk("R1 alloc_tag", 32'(alloc_tag), 32'(m_tail));
    h = m_head;
    e_dv = (m_count > 0) && m_valid[h] && !m_spec[h] && m_rdy[h];
    chk("R8 drain_valid", 32'(drain_valid), 32'(e_dv));
    if (e_dv) begin
      chk("R8 drain_addr", 32'(drain_addr), 32'(m_addr[h]));
      chk("R8 drain_data", drain_data, m_data[h]);
    end
    found = 0; frdy = 0; fdat = '0;
    for (int k = 0; k < DEPTH; k++) begin
      int idx;
      idx = (h + k) % DEPTH;
      if (m_valid[idx] && m_addr[idx] == la) begin
        found = 1; frdy = m_rdy[idx]; fdat = m_data[idx];
      end
    end
    e_hit = lv && found && frdy;
    e_pend = lv && found && !frdy;
    chk("R4 ld_hit", 32'(ld_hit), 32'(e_hit));
    chk("R5 ld_pending", 32'(ld_pending), 32'(e_pend));
    chk("R6 ld_data", ld_data, e_hit ? fdat : cd);
    // advance the model with this cycle's inputs
    pop = (m_count > 0) && (!m_valid[h] || (e_dv && dr));
    acc = av && (m_count < DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      n_valid[i] = m_valid[i]; n_spec[i] = m_spec[i];
      n_rdy[i] = m_rdy[i]; n_data[i] = m_data[i];
      if (pop && i == h) n_valid[i] = 0;
      else if (xv && xt == i && m_valid[i] && m_spec[i]) n_valid[i] = 0;
      else begin
        if (cv && ct == i && m_valid[i] && m_spec[i]) n_spec[i] = 0;
        if (fv && ft == i && m_valid[i] && !m_rdy[i]) begin
          n_rdy[i] = 1; n_data[i] = fd;
        end
      end
    end
    for (int i = 0; i < DEPTH; i++) begin
      m_valid[i] = n_valid[i]; m_spec[i] = n_spec[i];
      m_rdy[i] = n_rdy[i]; m_data[i] = n_data[i];
    end
    if (acc) begin
      m_valid[m_tail] = 1; m_spec[m_tail] = 1; m_rdy[m_tail] = 0;
      m_addr[m_tail] = aa;
      m_tail = (m_tail + 1) % DEPTH;
    end
    if (pop) m_head = (m_head + 1) % DEPTH;
    m_count = m_count + int'(acc) - int'(pop);
  endtask

  task automatic idle(input bit lv, input logic [AW-1:0] la, input bit dr);
    step(0, '0, 0, 0, '0, 0, 0, 0, 0, lv, la, 32'hCAC0_0000, dr);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      m_valid[i] = 0; m_spec[i] = 0; m_rdy[i] = 0; m_addr[i] = '0; m_data[i] = '0;
    end
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #2;
    // R10: empty after reset
    chk("R10 alloc_ready", 32'(alloc_ready), 32'd1);
    chk("R10 alloc_tag", 32'(alloc_tag), 32'd0);
    chk("R10 drain_valid", 32'(drain_valid), 32'd0);
    chk("R10 ld_hit", 32'(ld_hit), 32'd0);

    // R1: two stores to the same address, tags 0 and 1
    step(1, 16'h10, 0, 0, '0, 0, 0, 0, 0, 0, '0, '0, 0);
    step(1, 16'h10, 0, 0, '0, 0, 0, 0, 0, 0, '0, '0, 0);
    // R5: youngest match has no data
    idle(1, 16'h10, 0);
    // R6: older filled, youngest still empty -> pending
    step(0, '0, 1, 0, 32'hAAAA_0000, 0, 0, 0, 0, 0, '0, '0, 0);
    idle(1, 16'h10, 0);
    // R4: youngest filled overrides cache
    step(0, '0, 1, 1, 32'hBBBB_1111, 0, 0, 0, 0, 0, '0, '0, 0);
    idle(1, 16'h10, 0);
    // R3: second fill to a filled slot is ignored
    step(0, '0, 1, 1, 32'hDEAD_BEEF, 0, 0, 0, 0, 0, '0, '0, 0);
    idle(1, 16'h10, 0);
    // R7: abort the youngest, older one forwards; miss address reads cache
    step(0, '0, 0, 0, '0, 0, 0, 1, 1, 0, '0, '0, 0);
    idle(1, 16'h10, 0);
    idle(1, 16'h14, 0);
    // R8: commit head, stall drain, then accept; R9: aborted slot skipped
    step(0, '0, 0, 0, '0, 1, 0, 0, 0, 0, '0, '0, 0);
    idle(0, '0, 0);
    idle(0, '0, 0);
    idle(0, '0, 1);
    idle(0, '0, 1);
    idle(1, 16'h10, 1);
    // R2: fill all slots
    for (int i = 0; i < DEPTH + 2; i++)
      step(1, 16'h18, 0, 0, '0, 0, 0, 0, 0, 1, 16'h18, '0, 0);
    // R7: commit on a slot, then abort it -> ignored
    step(0, '0, 0, 0, '0, 1, 3, 0, 0, 0, '0, '0, 0);
    step(0, '0, 0, 0, '0, 0, 0, 1, 3, 1, 16'h18, '0, 0);

    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      step(($urandom % 2) == 0, AW'(16'h10 + 4 * ($urandom % 4)),
           ($urandom % 2) == 0, int'($urandom % DEPTH), $urandom,
           ($urandom % 5) < 2, int'($urandom % DEPTH),
           ($urandom % 10) == 0, int'($urandom % DEPTH),
           ($urandom % 4) != 0, AW'(16'h10 + 4 * ($urandom % 4)), $urandom,
           ($urandom % 5) < 3);
    end
    summary();
    $finish;
  end
endmodule